// File: doc/BRIEF.md
# Multichannel Temperature Limit Monitor

This block watches a stream of temperature samples, each tagged with a channel index, a valid strobe and a diode-fault flag, and keeps per-channel alarm state against three thresholds: a low limit, a high limit and a critical limit. Channel 0 is the on-die sensor. Channels 1 and up are remote diodes. The number of channels present is a parameter between 2 and 5.

A single hysteresis register holds a whole-degree distance. It sets the release point of every limit on every channel. An alarm is raised when a sample crosses its limit. It stays raised until a later sample moves past the release point on the safe side. A sample flagged as a diode fault only raises the fault bit. The four status vectors hold one bit per channel, and their OR drives a single alert pin. A byte-wide register port gives read and write access to the limits and the hysteresis, and read access to the status vectors.

Top module: `tmon_limit_top`

## Requirements
- R1: A temperature code is 11 bits, equal to (degrees C + 64) * 8. A low or high limit is the code {integer byte, fraction bits 7:5 of the fraction byte}. A critical limit is {critical byte, 3'b000}.
- R2: `NUM_CH` sets the number of channels, from 2 to 5. A sample whose index is NUM_CH or larger changes no status bit.
- R3: A valid sample without the fault flag sets the high alarm of its channel when code > high limit. It clears the alarm when code <= high limit - 8*hysteresis. For any other code the alarm keeps its value.
- R4: The low alarm sets when code < low limit. It clears when code >= low limit + 8*hysteresis. For any other code it keeps its value.
- R5: The critical alarm sets when code >= critical limit. It clears when code < critical limit - 8*hysteresis. For any other code it keeps its value.
- R6: The hysteresis register is at address 0x00 and resets to 10. Its single value applies to all limits of all channels.
- R7: A valid sample with the fault flag sets that channel's fault bit and leaves its low, high and critical bits unchanged. A valid sample without the flag clears the fault bit.
- R8: Status vectors are read at 0x01 (low), 0x02 (high), 0x03 (critical) and 0x04 (fault). Bit c belongs to channel c. Writes to these addresses are ignored. A sample is reflected in status on the clock edge that accepts it.
- R9: `alert` is high exactly when at least one status bit is set.
- R10: Channel c has its limit registers at 0x10 + 8*c, with offsets 0 high integer, 1 high fraction, 2 low integer, 3 low fraction and 4 critical. At reset the high limit is 0xFF/0xE0, the low limit is 0x00/0x00 and the critical limit is 0xFF.
- R11: Channel 0 has integer-only low and high limits. Its fraction registers read 0 and ignore writes.
- R12: When no valid sample is presented, no status bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_chan | input | 3 | Channel index of the sample |
| smp_temp | input | 11 | Temperature code |
| smp_fault | input | 1 | Diode fault flag for the sample |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| alert | output | 1 | OR of all status bits |

## Verification
The bench builds the block with the default of five channels. This puts the highest external index in range, together with indices 5 to 7, which exist on the select lines but name no channel. Every threshold kind is placed on its own channel so that a crossed channel decode shows up. A non-default hysteresis of 3 is then reused on two channels to show that the value is shared. The internal channel is given a write to its fraction byte before its high limit is tested at one code above the integer limit.

// File: rtl/tmon_pkg.sv
package tmon_pkg;
   localparam int MAX_CH  = 5;
   localparam int CH_W    = 3;
   localparam int BYTE_W  = 8;
   localparam int FRAC_W  = 3;
   localparam int TEMP_W  = BYTE_W + FRAC_W;

   localparam logic [7:0] ADR_HYST     = 8'h00;
   localparam logic [7:0] ADR_ST_LOW   = 8'h01;
   localparam logic [7:0] ADR_ST_HIGH  = 8'h02;
   localparam logic [7:0] ADR_ST_CRIT  = 8'h03;
   localparam logic [7:0] ADR_ST_FAULT = 8'h04;
   localparam logic [7:0] ADR_CH_BASE  = 8'h10;

   typedef enum logic [2:0] {
      FLD_HIGH_I = 3'd0,
      FLD_HIGH_F = 3'd1,
      FLD_LOW_I  = 3'd2,
      FLD_LOW_F  = 3'd3,
      FLD_CRIT   = 3'd4
   } lim_fld_e;
endpackage

// File: rtl/tmon_limit_regs.sv
module tmon_limit_regs
   import tmon_pkg::*;
#(
   parameter int          NUM_CH   = 5,
   parameter logic [7:0]  HYST_RST = 8'd10
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [7:0]                       addr,
   input  logic [7:0]                       wdata,
   output logic [NUM_CH-1:0][TEMP_W-1:0]    lim_high,
   output logic [NUM_CH-1:0][TEMP_W-1:0]    lim_low,
   output logic [NUM_CH-1:0][TEMP_W-1:0]    lim_crit,
   output logic [BYTE_W-1:0]                hyst,
   output logic [7:0]                       rdata,
   output logic                             hit
);
   logic [7:0]  off;
   logic [4:0]  sel_ch;
   lim_fld_e    fld;
   logic        in_win;
   logic        hyst_sel;
   logic [NUM_CH-1:0][7:0] ch_rd;

   assign off      = addr - ADR_CH_BASE;
   assign sel_ch   = off[7:3];
   assign fld      = lim_fld_e'(off[2:0]);
   assign in_win   = (addr >= ADR_CH_BASE) && (int'(sel_ch) < NUM_CH) && (off[2:0] <= 3'd4);
   assign hyst_sel = (addr == ADR_HYST);
   assign hit      = in_win || hyst_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                hyst <= HYST_RST;
      else if (wr_en && hyst_sel) hyst <= wdata;
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic              wr_c;
      logic [7:0]        hi_i, lo_i, cr_i;
      logic [FRAC_W-1:0] hi_f, lo_f;

      assign wr_c = wr_en && in_win && (sel_ch == 5'(c));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hi_i <= 8'hFF;
            lo_i <= 8'h00;
            cr_i <= 8'hFF;
         end else if (wr_c) begin
            if (fld == FLD_HIGH_I) hi_i <= wdata;
            if (fld == FLD_LOW_I)  lo_i <= wdata;
            if (fld == FLD_CRIT)   cr_i <= wdata;
         end
      end

      if (c == 0) begin : g_int
         assign hi_f = '0;
         assign lo_f = '0;
      end else begin : g_ext
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hi_f <= '1;
               lo_f <= '0;
            end else if (wr_c) begin
               if (fld == FLD_HIGH_F) hi_f <= wdata[7:8-FRAC_W];
               if (fld == FLD_LOW_F)  lo_f <= wdata[7:8-FRAC_W];
            end
         end
      end

      assign lim_high[c] = {hi_i, hi_f};
      assign lim_low[c]  = {lo_i, lo_f};
      assign lim_crit[c] = {cr_i, {FRAC_W{1'b0}}};

      always_comb begin
         case (fld)
            FLD_HIGH_I: ch_rd[c] = hi_i;
            FLD_HIGH_F: ch_rd[c] = {hi_f, {(8-FRAC_W){1'b0}}};
            FLD_LOW_I:  ch_rd[c] = lo_i;
            FLD_LOW_F:  ch_rd[c] = {lo_f, {(8-FRAC_W){1'b0}}};
            FLD_CRIT:   ch_rd[c] = cr_i;
            default:    ch_rd[c] = 8'h00;
         endcase
      end
   end

   always_comb begin
      rdata = 8'h00;
      if (hyst_sel) rdata = hyst;
      for (int c = 0; c < NUM_CH; c++) begin
         if (in_win && sel_ch == 5'(c)) rdata = ch_rd[c];
      end
   end
endmodule

// File: rtl/tmon_chan_eval.sv
module tmon_chan_eval
   import tmon_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit,
   input  logic              fault,
   input  logic [TEMP_W-1:0] temp,
   input  logic [TEMP_W-1:0] lim_high,
   input  logic [TEMP_W-1:0] lim_low,
   input  logic [TEMP_W-1:0] lim_crit,
   input  logic [BYTE_W-1:0] hyst,
   output logic              al_low,
   output logic              al_high,
   output logic              al_crit,
   output logic              al_fault
);
   localparam int EW  = TEMP_W + 2;
   localparam int PAD = EW - TEMP_W;

   logic signed [EW-1:0] t_s, hi_s, lo_s, cr_s, hc_s;
   logic signed [EW-1:0] rel_hi, rel_lo, rel_cr;

   assign t_s    = signed'({{PAD{1'b0}}, temp});
   assign hi_s   = signed'({{PAD{1'b0}}, lim_high});
   assign lo_s   = signed'({{PAD{1'b0}}, lim_low});
   assign cr_s   = signed'({{PAD{1'b0}}, lim_crit});
   assign hc_s   = signed'({{PAD{1'b0}}, hyst, {FRAC_W{1'b0}}});
   assign rel_hi = hi_s - hc_s;
   assign rel_lo = lo_s + hc_s;
   assign rel_cr = cr_s - hc_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         al_low   <= 1'b0;
         al_high  <= 1'b0;
         al_crit  <= 1'b0;
         al_fault <= 1'b0;
      end else if (hit) begin
         if (fault) begin
            al_fault <= 1'b1;
         end else begin
            al_fault <= 1'b0;
            if (t_s > hi_s)        al_high <= 1'b1;
            else if (t_s <= rel_hi) al_high <= 1'b0;
            if (t_s < lo_s)        al_low <= 1'b1;
            else if (t_s >= rel_lo) al_low <= 1'b0;
            if (t_s >= cr_s)       al_crit <= 1'b1;
            else if (t_s < rel_cr)  al_crit <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/tmon_limit_top.sv
module tmon_limit_top
   import tmon_pkg::*;
#(
   parameter int         NUM_CH   = 5,
   parameter logic [7:0] HYST_RST = 8'd10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic [CH_W-1:0]   smp_chan,
   input  logic [TEMP_W-1:0] smp_temp,
   input  logic              smp_fault,
   input  logic              reg_wr,
   input  logic [7:0]        reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic              alert
);
   localparam int ST_PAD = 8 - NUM_CH;

   if (NUM_CH < 2 || NUM_CH > MAX_CH) begin : g_bad_num_ch
      $error("tmon_limit_top: NUM_CH must lie in 2..%0d", MAX_CH);
   end
   if (TEMP_W != BYTE_W + FRAC_W) begin : g_bad_temp_w
      $error("tmon_limit_top: code width must be byte plus fraction");
   end

   logic [NUM_CH-1:0][TEMP_W-1:0] lim_high, lim_low, lim_crit;
   logic [BYTE_W-1:0]             hyst;
   logic [7:0]                    lim_rd;
   logic                          lim_hit;
   logic [NUM_CH-1:0]             st_low, st_high, st_crit, st_fault;

   tmon_limit_regs #(
      .NUM_CH   (NUM_CH),
      .HYST_RST (HYST_RST)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .lim_high (lim_high),
      .lim_low  (lim_low),
      .lim_crit (lim_crit),
      .hyst     (hyst),
      .rdata    (lim_rd),
      .hit      (lim_hit)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_eval
      logic ch_hit;
      assign ch_hit = smp_valid && (smp_chan == CH_W'(c));

      tmon_chan_eval u_eval (
         .clk      (clk),
         .rst_n    (rst_n),
         .hit      (ch_hit),
         .fault    (smp_fault),
         .temp     (smp_temp),
         .lim_high (lim_high[c]),
         .lim_low  (lim_low[c]),
         .lim_crit (lim_crit[c]),
         .hyst     (hyst),
         .al_low   (st_low[c]),
         .al_high  (st_high[c]),
         .al_crit  (st_crit[c]),
         .al_fault (st_fault[c])
      );
   end

   always_comb begin
      if (lim_hit) begin
         reg_rdata = lim_rd;
      end else begin
         case (reg_addr)
            ADR_ST_LOW:   reg_rdata = {{ST_PAD{1'b0}}, st_low};
            ADR_ST_HIGH:  reg_rdata = {{ST_PAD{1'b0}}, st_high};
            ADR_ST_CRIT:  reg_rdata = {{ST_PAD{1'b0}}, st_crit};
            ADR_ST_FAULT: reg_rdata = {{ST_PAD{1'b0}}, st_fault};
            default:      reg_rdata = 8'h00;
         endcase
      end
   end

   assign alert = |{st_low, st_high, st_crit, st_fault};
endmodule

// File: rtl/tmon_limit_chk.sv
module tmon_limit_chk
   import tmon_pkg::*;
#(
   parameter int NUM_CH = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              smp_valid,
   input logic [CH_W-1:0]   smp_chan,
   input logic              smp_fault,
   input logic              alert,
   input logic [NUM_CH-1:0] st_low,
   input logic [NUM_CH-1:0] st_high,
   input logic [NUM_CH-1:0] st_crit,
   input logic [NUM_CH-1:0] st_fault
);
   // R12: with no sample, all status stays put
   a_r12_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> ($stable(st_low) && $stable(st_high) && $stable(st_crit) && $stable(st_fault)));

   // R2: out-of-range channel index leaves all status untouched
   a_r2_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && int'(smp_chan) >= NUM_CH)
      |=> ($stable(st_low) && $stable(st_high) && $stable(st_crit) && $stable(st_fault)));

   // R7: a faulty sample keeps limit alarms unchanged
   a_r7_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && smp_fault) |=> ($stable(st_low) && $stable(st_high) && $stable(st_crit)));

   // R9: alert can only rise after a sample was taken
   a_r9_alert_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alert) |-> $past(smp_valid));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      // R7: fault flag on channel c sets its fault bit
      a_r7_fault_bit: assert property (@(posedge clk) disable iff (!rst_n)
         (smp_valid && smp_fault && smp_chan == CH_W'(c)) |=> st_fault[c]);
   end
endmodule

bind tmon_limit_top tmon_limit_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .smp_valid (smp_valid),
   .smp_chan  (smp_chan),
   .smp_fault (smp_fault),
   .alert     (alert),
   .st_low    (st_low),
   .st_high   (st_high),
   .st_crit   (st_crit),
   .st_fault  (st_fault)
);

// File: tb/tmon_limit_top_tb.sv
module tmon_limit_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_valid = 1'b0;
   logic [2:0]  smp_chan = '0;
   logic [10:0] smp_temp = '0;
   logic        smp_fault = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        alert;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   tmon_limit_top #(.NUM_CH(5)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_valid (smp_valid),
      .smp_chan  (smp_chan),
      .smp_temp  (smp_temp),
      .smp_fault (smp_fault),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .alert     (alert)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output int d);
      @(negedge clk);
      reg_addr = a;
      #1 d = int'(reg_rdata);
   endtask

   task automatic smp(input int ch, input int t, input bit f);
      @(negedge clk);
      smp_valid = 1'b1; smp_chan = 3'(ch); smp_temp = 11'(t); smp_fault = f;
      @(negedge clk);
      smp_valid = 1'b0; smp_fault = 1'b0;
   endtask

   task automatic chk_rd(input string req, input string what, input logic [7:0] a, input int exp);
      int v;
      rd(a, v);
      chk(req, what, v, exp);
   endtask

   task automatic t_reset();
      chk_rd("R6", "hysteresis reset", 8'h00, 10);
      chk_rd("R8", "low status reset", 8'h01, 0);
      chk_rd("R8", "fault status reset", 8'h04, 0);
      chk("R9", "alert reset", int'(alert), 0);
      chk_rd("R10", "ch1 high int reset", 8'h18, 8'hFF);
      chk_rd("R10", "ch1 high frac reset", 8'h19, 8'hE0);
      chk_rd("R10", "ch2 low int reset", 8'h22, 8'h00);
      chk_rd("R10", "ch3 crit reset", 8'h2C, 8'hFF);
      chk_rd("R11", "ch0 high frac reset", 8'h11, 0);
   endtask

   task automatic t_high();
      wr(8'h18, 8'h90); wr(8'h19, 8'h80);     // code 1156
      smp(1, 1156, 0);
      chk_rd("R1", "high at limit stays clear", 8'h02, 0);
      smp(1, 1157, 0);
      chk_rd("R3", "high set above limit", 8'h02, 8'h02);
      chk("R9", "alert with high", int'(alert), 1);
      smp(1, 1100, 0);
      chk_rd("R3", "high held in band", 8'h02, 8'h02);
      smp(1, 1076, 0);
      chk_rd("R3", "high cleared at release", 8'h02, 0);
      chk("R9", "alert after clear", int'(alert), 0);
   endtask

   task automatic t_low();
      wr(8'h22, 8'h40); wr(8'h23, 8'h00);     // code 512
      smp(2, 511, 0);
      chk_rd("R4", "low set below limit", 8'h01, 8'h04);
      smp(2, 591, 0);
      chk_rd("R4", "low held in band", 8'h01, 8'h04);
      smp(2, 592, 0);
      chk_rd("R4", "low cleared at release", 8'h01, 0);
   endtask

   task automatic t_crit();
      wr(8'h2C, 8'hA4);                       // code 1312
      smp(3, 1311, 0);
      chk_rd("R5", "crit below limit clear", 8'h03, 0);
      smp(3, 1312, 0);
      chk_rd("R5", "crit set at limit", 8'h03, 8'h08);
      smp(3, 1232, 0);
      chk_rd("R5", "crit held at release", 8'h03, 8'h08);
      smp(3, 1231, 0);
      chk_rd("R5", "crit cleared below release", 8'h03, 0);
   endtask

   task automatic t_shared_hyst();
      wr(8'h00, 8'd3);
      chk_rd("R6", "hysteresis write", 8'h00, 3);
      wr(8'h30, 8'h70); wr(8'h31, 8'h00);     // ch4 high code 896
      smp(4, 897, 0);
      chk_rd("R3", "ch4 high set", 8'h02, 8'h10);
      smp(4, 873, 0);
      chk_rd("R6", "ch4 high held with hyst 3", 8'h02, 8'h10);
      smp(4, 872, 0);
      chk_rd("R6", "ch4 high released with hyst 3", 8'h02, 0);
      smp(3, 1312, 0);
      smp(3, 1288, 0);
      chk_rd("R6", "ch3 crit held with hyst 3", 8'h03, 8'h08);
      smp(3, 1287, 0);
      chk_rd("R6", "ch3 crit released with hyst 3", 8'h03, 0);
   endtask

   task automatic t_internal();
      wr(8'h11, 8'hE0);
      chk_rd("R11", "ch0 frac write ignored", 8'h11, 0);
      wr(8'h10, 8'h80);                       // code 1024
      chk_rd("R10", "ch0 high int write", 8'h10, 8'h80);
      smp(0, 1024, 0);
      chk_rd("R3", "ch0 at limit clear", 8'h02, 0);
      smp(0, 1025, 0);
      chk_rd("R11", "ch0 integer-only limit", 8'h02, 8'h01);
      smp(0, 1000, 0);
      chk_rd("R3", "ch0 high released", 8'h02, 0);
   endtask

   task automatic t_fault();
      wr(8'h1A, 8'h40);                       // ch1 low code 512
      smp(1, 1157, 0);
      chk_rd("R3", "ch1 high before fault", 8'h02, 8'h02);
      smp(1, 0, 1);
      chk_rd("R7", "fault bit set", 8'h04, 8'h02);
      chk_rd("R7", "high kept on fault", 8'h02, 8'h02);
      chk_rd("R7", "low untouched on fault", 8'h01, 0);
      chk("R9", "alert with fault", int'(alert), 1);
      smp(1, 800, 0);
      chk_rd("R7", "fault cleared by good sample", 8'h04, 0);
      chk_rd("R3", "high released after fault", 8'h02, 0);
      chk("R9", "alert all clear", int'(alert), 0);
   endtask

   task automatic t_ignored();
      smp(2, 100, 0);
      chk_rd("R4", "ch2 low set", 8'h01, 8'h04);
      wr(8'h01, 8'h00); wr(8'h02, 8'hFF); wr(8'h03, 8'hFF); wr(8'h04, 8'hFF);
      chk_rd("R8", "low status write ignored", 8'h01, 8'h04);
      chk_rd("R8", "high status write ignored", 8'h02, 0);
      chk_rd("R8", "fault status write ignored", 8'h04, 0);
      smp(5, 0, 1);
      smp(7, 2047, 0);
      chk_rd("R2", "index 5 and 7 no fault", 8'h04, 0);
      chk_rd("R2", "index 7 no high", 8'h02, 0);
      chk_rd("R2", "index 7 no crit", 8'h03, 0);
      repeat (5) @(negedge clk);
      chk_rd("R12", "low held while idle", 8'h01, 8'h04);
      smp(2, 536, 0);
      chk_rd("R4", "ch2 low released", 8'h01, 0);
      chk("R9", "alert final", int'(alert), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_high();
      t_low();
      t_crit();
      t_shared_hyst();
      t_internal();
      t_fault();
      t_ignored();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule